// File: doc/BRIEF.md
# Displacement and Immediate Byte Assembler

This block sits behind an instruction-length decoder. Once the decoder knows how many displacement bytes and how many immediate bytes follow the opcode, it pulses `start_i` with both sizes, the sign-extension request and the current operand width. The fetch side then delivers the trailing bytes one per cycle on `byte_i` and flags each with `byte_valid_i`. The block stores them little-endian. The displacement bytes come first in the run and the immediate bytes follow them directly.

When the last byte has been accepted, the block raises `done_o` for one cycle. It then presents a 32-bit displacement, always sign-extended from its own length, and a 32-bit immediate. The immediate is sign-extended only when sign extension was requested and its size differs from the operand width; in every other case it is zero-extended. While bytes are still owed, `remaining_o` tells the fetch side how many are outstanding. Both results hold their values until the next `start_i`.

Size codes on every size input: 0 = none, 1 = one byte, 2 = two bytes, 3 = four bytes.

Top module: `dimm_assembler`

## Requirements
- R1: After reset, `done_o` is 0, `remaining_o` is 0, and `disp_o` and `imm_o` are 0.
- R2: Accepted bytes are packed little-endian. The k-th accepted byte of the run occupies bits [8k+7:8k] of the run.
- R3: `disp_o` holds the first 1, 2 or 4 bytes of the run, sign-extended to 32 bits from bit 7, 15 or 31. With size code 0 it is 0.
- R4: The immediate is taken from the bytes that directly follow the displacement bytes.
- R5: When `sext_req_i` was 1 at start and the immediate size code differs from `op_width_i`, `imm_o` is sign-extended from the immediate's top bit.
- R6: Otherwise `imm_o` is zero-extended. This includes the case where sext is requested but the immediate size equals `op_width_i`.
- R7: From the cycle after start, `remaining_o` equals the total byte count minus the bytes accepted so far. A cycle without `byte_valid_i` leaves it unchanged.
- R8: A start with both size codes 0 gives `done_o` = 1 in the next cycle, with `disp_o` and `imm_o` both 0.
- R9: `done_o` is high for exactly one cycle per run unless a new start arrives. `disp_o` and `imm_o` do not change while `remaining_o` is 0 and no start is given.
- R10: `start_i` clears the stored bytes and restarts the run, even in the middle of a run. A byte offered in the same cycle as `start_i` is ignored.
- R11: `remaining_o` never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new run with the sizes below |
| disp_size_i | input | 2 | Displacement size code |
| imm_size_i | input | 2 | Immediate size code |
| sext_req_i | input | 1 | Request sign extension of the immediate |
| op_width_i | input | 2 | Current operand width code |
| byte_i | input | 8 | Next instruction byte |
| byte_valid_i | input | 1 | `byte_i` is valid this cycle |
| disp_o | output | 32 | Sign-extended displacement |
| imm_o | output | 32 | Extended immediate |
| done_o | output | 1 | One-cycle completion strobe |
| remaining_o | output | 4 | Bytes still outstanding |

## Verification
Two events can fall in the same cycle: the completion strobe of one run and the start of the next. The bench raises `start_i` exactly in the cycle where `done_o` is high. It then checks that the finished results were visible in that cycle, that `done_o` drops in the next cycle, and that `remaining_o` already shows the new run's byte count. A second collision is also covered: a start offered together with a valid byte in the middle of a run. That byte must be dropped and the earlier bytes forgotten.

// File: rtl/dimm_pkg.sv
package dimm_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned MAX_BYTES = 8;
  localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int unsigned IDX_W     = $clog2(MAX_BYTES);

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_B    = 2'd1,
    SZ_W    = 2'd2,
    SZ_D    = 2'd3
  } size_e;

  function automatic logic [CNT_W-1:0] size_bytes(input size_e s);
    case (s)
      SZ_B:    size_bytes = CNT_W'(1);
      SZ_W:    size_bytes = CNT_W'(2);
      SZ_D:    size_bytes = CNT_W'(4);
      default: size_bytes = '0;
    endcase
  endfunction
endpackage

// File: rtl/dimm_ctrl.sv
module dimm_ctrl
  import dimm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  size_e            disp_size_i,
  input  size_e            imm_size_i,
  input  logic             sext_req_i,
  input  size_e            op_width_i,
  input  logic             byte_valid_i,
  output logic             clear_o,
  output logic             we_o,
  output logic [IDX_W-1:0] idx_o,
  output size_e            disp_sz_o,
  output size_e            imm_sz_o,
  output logic             imm_signed_o,
  output logic             done_o,
  output logic [CNT_W-1:0] remaining_o
);
  logic [CNT_W-1:0] total_q, cnt_q, start_total;
  logic             busy_q, done_q;

  assign start_total = size_bytes(disp_size_i) + size_bytes(imm_size_i);
  assign clear_o     = start_i;
  assign we_o        = busy_q && byte_valid_i && !start_i;
  assign idx_o       = cnt_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q      <= '0;
      cnt_q        <= '0;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      disp_sz_o    <= SZ_NONE;
      imm_sz_o     <= SZ_NONE;
      imm_signed_o <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        total_q      <= start_total;
        cnt_q        <= '0;
        disp_sz_o    <= disp_size_i;
        imm_sz_o     <= imm_size_i;
        imm_signed_o <= sext_req_i && (imm_size_i != op_width_i);
        busy_q       <= (start_total != '0);
        done_q       <= (start_total == '0);
      end else if (we_o) begin
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q + CNT_W'(1) == total_q) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o      = done_q;
  assign remaining_o = busy_q ? (total_q - cnt_q) : '0;

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);
  // R11
  remaining_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remaining_o <= CNT_W'(MAX_BYTES));
  // R7
  remaining_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remaining_o != '0 && byte_valid_i && !start_i) |=> remaining_o == $past(remaining_o) - CNT_W'(1));
  // R7
  remaining_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!byte_valid_i && !start_i) |=> $stable(remaining_o));
  // R8
  empty_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && disp_size_i == SZ_NONE && imm_size_i == SZ_NONE) |=> (done_o && remaining_o == '0));
endmodule

// File: rtl/dimm_accum.sv
module dimm_accum
  import dimm_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   clear_i,
  input  logic                   we_i,
  input  logic [IDX_W-1:0]       idx_i,
  input  logic [7:0]             byte_i,
  output logic [8*MAX_BYTES-1:0] acc_o
);
  for (genvar k = 0; k < MAX_BYTES; k++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                lane_q <= '0;
      else if (clear_i)                           lane_q <= '0;
      else if (we_i && idx_i == IDX_W'(k))        lane_q <= byte_i;
    end
    assign acc_o[8*k +: 8] = lane_q;
  end
endmodule

// File: rtl/dimm_extend.sv
module dimm_extend
  import dimm_pkg::*;
(
  input  logic [8*MAX_BYTES-1:0] acc_i,
  input  size_e                  disp_sz_i,
  input  size_e                  imm_sz_i,
  input  logic                   imm_signed_i,
  output logic [DATA_W-1:0]      disp_o,
  output logic [DATA_W-1:0]      imm_o
);
  logic [DATA_W-1:0] imm_raw;

  always_comb begin
    case (disp_sz_i)
      SZ_B:    disp_o = {{24{acc_i[7]}},  acc_i[7:0]};
      SZ_W:    disp_o = {{16{acc_i[15]}}, acc_i[15:0]};
      SZ_D:    disp_o = acc_i[31:0];
      default: disp_o = '0;
    endcase
  end

  // immediate starts right after the displacement lanes
  always_comb begin
    case (disp_sz_i)
      SZ_B:    imm_raw = acc_i[39:8];
      SZ_W:    imm_raw = acc_i[47:16];
      SZ_D:    imm_raw = acc_i[63:32];
      default: imm_raw = acc_i[31:0];
    endcase
  end

  always_comb begin
    case (imm_sz_i)
      SZ_B:    imm_o = {{24{imm_signed_i & imm_raw[7]}},  imm_raw[7:0]};
      SZ_W:    imm_o = {{16{imm_signed_i & imm_raw[15]}}, imm_raw[15:0]};
      SZ_D:    imm_o = imm_raw;
      default: imm_o = '0;
    endcase
  end
endmodule

// File: rtl/dimm_assembler.sv
module dimm_assembler
  import dimm_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  disp_size_i,
  input  logic [1:0]  imm_size_i,
  input  logic        sext_req_i,
  input  logic [1:0]  op_width_i,
  input  logic [7:0]  byte_i,
  input  logic        byte_valid_i,
  output logic [31:0] disp_o,
  output logic [31:0] imm_o,
  output logic        done_o,
  output logic [3:0]  remaining_o
);
  logic                   clear, we, imm_signed;
  logic [IDX_W-1:0]       idx;
  size_e                  disp_sz, imm_sz;
  logic [8*MAX_BYTES-1:0] acc;
  logic [CNT_W-1:0]       remaining;

  dimm_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .disp_size_i  (size_e'(disp_size_i)),
    .imm_size_i   (size_e'(imm_size_i)),
    .sext_req_i   (sext_req_i),
    .op_width_i   (size_e'(op_width_i)),
    .byte_valid_i (byte_valid_i),
    .clear_o      (clear),
    .we_o         (we),
    .idx_o        (idx),
    .disp_sz_o    (disp_sz),
    .imm_sz_o     (imm_sz),
    .imm_signed_o (imm_signed),
    .done_o       (done_o),
    .remaining_o  (remaining)
  );

  dimm_accum u_accum (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .we_i    (we),
    .idx_i   (idx),
    .byte_i  (byte_i),
    .acc_o   (acc)
  );

  dimm_extend u_extend (
    .acc_i        (acc),
    .disp_sz_i    (disp_sz),
    .imm_sz_i     (imm_sz),
    .imm_signed_i (imm_signed),
    .disp_o       (disp_o),
    .imm_o        (imm_o)
  );

  assign remaining_o = 4'(remaining);

  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (remaining_o == '0 && !start_i) |=> ($stable(disp_o) && $stable(imm_o)));
  // R10
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (disp_o == '0 && imm_o == '0));
endmodule

// File: tb/dimm_assembler_tb.sv
module dimm_assembler_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  dsz = '0, isz = '0, wid = '0;
  logic        sext = 1'b0;
  logic [7:0]  bdat = '0;
  logic        bval = 1'b0;
  logic [31:0] disp, imm;
  logic        done;
  logic [3:0]  rem;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #4 clk = ~clk;

  dimm_assembler u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .disp_size_i(dsz),
    .imm_size_i(isz), .sext_req_i(sext), .op_width_i(wid), .byte_i(bdat),
    .byte_valid_i(bval), .disp_o(disp), .imm_o(imm), .done_o(done),
    .remaining_o(rem)
  );

  typedef struct packed {
    logic [1:0]  d;
    logic [1:0]  i;
    logic        s;
    logic [1:0]  w;
    logic [63:0] bytes;
    logic [31:0] ed;
    logic [31:0] ei;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VT [NV] = '{
    '{2'd1, 2'd0, 1'b0, 2'd2, 64'h80,               32'hFFFFFF80, 32'h0},
    '{2'd2, 2'd0, 1'b0, 2'd2, 64'h1234,             32'h00001234, 32'h0},
    '{2'd3, 2'd0, 1'b0, 2'd2, 64'hF2345678,         32'hF2345678, 32'h0},
    '{2'd0, 2'd1, 1'b1, 2'd2, 64'hF0,               32'h0,        32'hFFFFFFF0},
    '{2'd0, 2'd1, 1'b0, 2'd2, 64'hF0,               32'h0,        32'h000000F0},
    '{2'd0, 2'd2, 1'b1, 2'd2, 64'h8000,             32'h0,        32'h00008000},
    '{2'd2, 2'd1, 1'b1, 2'd3, 64'h85FFFE,           32'hFFFFFFFE, 32'hFFFFFF85},
    '{2'd3, 2'd3, 1'b0, 2'd3, 64'hDDCCBBAA04030201, 32'h04030201, 32'hDDCCBBAA},
    '{2'd1, 2'd2, 1'b1, 2'd3, 64'h92347F,           32'h0000007F, 32'hFFFF9234},
    '{2'd2, 2'd2, 1'b0, 2'd2, 64'hFFFF8000,         32'hFFFF8000, 32'h0000FFFF}
  };

  function automatic int nb(input logic [1:0] c);
    return (c == 2'd3) ? 4 : int'(c);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000", cyc);
      report();
    end
  end

  task automatic kick(input logic [1:0] d, input logic [1:0] i, input logic s, input logic [1:0] w);
    start = 1'b1; dsz = d; isz = i; sext = s; wid = w;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic feed(input logic [7:0] b);
    bval = 1'b1; bdat = b;
    @(negedge clk);
    bval = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", 32'(done), 0);
    chk("R1 remaining", 32'(rem), 0);
    chk("R1 disp", disp, 0);
    chk("R1 imm", imm, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      int n;
      n = nb(VT[v].d) + nb(VT[v].i);
      kick(VT[v].d, VT[v].i, VT[v].s, VT[v].w);
      chk("R7 remaining after start", 32'(rem), 32'(n));
      for (int k = 0; k < n; k++) begin
        chk("R9 no early done", 32'(done), 0);
        feed(VT[v].bytes[8*k +: 8]);
      end
      // R2 R3 R4 R5 R6
      chk("R8 done strobe", 32'(done), 1);
      chk("R3 disp", disp, VT[v].ed);
      chk("R4 R5 R6 imm", imm, VT[v].ei);
      @(negedge clk);
      chk("R9 done dropped", 32'(done), 0);
      chk("R9 disp held", disp, VT[v].ed);
      chk("R9 imm held", imm, VT[v].ei);
    end

    // R8 both sizes zero
    kick(2'd0, 2'd0, 1'b1, 2'd2);
    chk("R8 done", 32'(done), 1);
    chk("R8 disp", disp, 0);
    chk("R8 imm", imm, 0);
    @(negedge clk);
    chk("R8 single", 32'(done), 0);

    // R7 gaps do not advance
    kick(2'd2, 2'd0, 1'b0, 2'd2);
    feed(8'h11);
    repeat (3) @(negedge clk);
    chk("R7 hold", 32'(rem), 1);
    feed(8'h22);
    chk("R7 done after gap", 32'(done), 1);
    chk("R2 gap disp", disp, 32'h00002211);

    // R10 restart mid-run, byte in start cycle ignored
    kick(2'd3, 2'd0, 1'b0, 2'd2);
    feed(8'hAA);
    feed(8'hBB);
    bval = 1'b1; bdat = 8'h55;
    kick(2'd1, 2'd0, 1'b0, 2'd2);
    bval = 1'b0;
    chk("R10 remaining", 32'(rem), 1);
    chk("R10 cleared", disp, 0);
    feed(8'h01);
    chk("R10 done", 32'(done), 1);
    chk("R10 disp", disp, 32'h1);

    // R9 start in the done cycle
    kick(2'd0, 2'd1, 1'b0, 2'd1);
    feed(8'h9C);
    chk("R9 overlap done", 32'(done), 1);
    chk("R6 equal width zero-ext", imm, 32'h9C);
    kick(2'd3, 2'd3, 1'b0, 2'd3);
    chk("R9 overlap done drops", 32'(done), 0);
    chk("R11 remaining eight", 32'(rem), 8);

    report();
  end
endmodule